// File: doc/BRIEF.md
# Scatter-Gather Descriptor Dispatcher

This block is the register-facing front end of a scatter-gather DMA engine. Software sees two address windows. The first is a small control and status space. The second is an eight-word descriptor window. The seven leading descriptor words only fill staging registers. Writing the control word (slot 7, byte offset 0x1C) with its go bit (bit 31) set commits all eight words as one entry into a descriptor FIFO. If the FIFO is full, that write is dropped and a sticky overflow flag is raised.

Queued descriptors are handed one at a time to the data movers over a valid/ready interface. The data movers return a completion event with an 8-bit error code and an early-termination flag. The block tracks the one descriptor in flight. Completion events drive a sticky interrupt flag and the optional stop-on-error and stop-on-early policies. A soft reset runs a fixed four-cycle flush, and software sees it through a resetting status bit that it can poll.

Both windows are word-indexed: `csr_addr` is the byte offset divided by four, and `dsc_addr` is the descriptor slot. Register reads are combinational.

Top module: `dma_dispatch_csr`

## Requirements
- R1: After reset, status reads 0x0000000A (descriptor-empty bit 1 and response-empty bit 3 set, all others clear), the fill and sequence words read 0, `xfer_valid` is 0 and `irq` is 0.
- R2: Writes to descriptor slots 0..6 only update staging. A slot-7 write with bit 31 set pushes one entry built from slot k into `xfer_desc[32k+31:32k]`, with slot 7 taking the written word. A slot-7 write with bit 31 clear pushes nothing.
- R3: A go write while the FIFO holds DEPTH entries is dropped and sets sticky status bit 10. Writing 1 to status bit 10 clears it.
- R4: Status bits 0..4 are live. Bit 0 is busy (FIFO not empty or a descriptor in flight). Bit 1 is FIFO empty and bit 2 is FIFO full. Bit 3 means nothing is in flight and bit 4 means one is in flight. Word 2 holds the FIFO count in both halves, and word 3 holds the in-flight count.
- R5: `xfer_valid` is 1 only when all of these hold: the FIFO is non-empty, nothing is in flight, status bit 5 is clear, control bit 5 (stop fetching) is clear, and no reset is running. Only one descriptor is in flight at a time. Word 4 counts accepted descriptors in bits 15:0 and completions in bits 31:16.
- R6: A completion sets sticky status bit 9 when any of these holds for the in-flight control word: its bit 14 is set; the error code ANDed with its bits 23:16 is nonzero; or the early flag is set and its bit 15 is set. Writing 1 to status bit 9 clears it.
- R7: `irq` equals status bit 9 ANDed with control bit 4.
- R8: With control bit 2 set, a completion with a nonzero error sets status bits 7 and 5 and stops dispatch. With control bit 3 set, an early completion sets status bits 8 and 5. Writing 1 to bit 7 or bit 8 clears that flag and resumes dispatch. Control bit 0 also forces status bit 5.
- R9: Writing control bit 1 makes status bit 6 read 1 for exactly four cycles. During that time the FIFO, the staging words, the in-flight slot, the sequence counts and status bits 7, 8 and 10 are cleared. Descriptor writes and completions are ignored while the reset runs.
- R10: The control word reads back bits 0 and 2..5 as written. Bit 1 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 3 | Register word index (0 status, 1 control, 2 fill, 3 in-flight, 4 sequence) |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for `csr_addr` |
| dsc_wr | input | 1 | Descriptor slot write strobe |
| dsc_addr | input | 3 | Descriptor slot index, 7 is the control word |
| dsc_wdata | input | 32 | Descriptor slot write data |
| xfer_valid | output | 1 | A descriptor is offered to the data movers |
| xfer_ready | input | 1 | Data movers accept the offered descriptor |
| xfer_desc | output | 256 | Offered descriptor, slot k in bits 32k+31:32k |
| done_valid | input | 1 | Completion event for the in-flight descriptor |
| done_err | input | 8 | Error code of the completion |
| done_early | input | 1 | Completion ended by early termination |
| irq | output | 1 | Interrupt request |

## Verification
The interrupt rule is tested with a table of completions. The rows pair control words with error codes and early flags. Some rows enable the completion interrupt. Some have error codes that the mask bits select, and others have error codes the mask does not select. Some have early termination with the early enable set or clear. This separates each term of the rule and catches a mask that is ignored or inverted. Every row also checks the full 256-bit descriptor against the eight words written, which exposes any slot misplacement. Directed sequences then cover:
- filling the FIFO while fetching is held off, then one more go write past full
- a go write with bit 31 clear
- a soft reset with stale staging data
- both stop policies, each followed by its release
- turning off the global interrupt enable while a flag is pending

// File: rtl/dd_pkg.sv
package dd_pkg;
  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 8;
  localparam int DESC_W     = WORD_W * DESC_WORDS;
  localparam int SLOT_W     = $clog2(DESC_WORDS);
  localparam int CTL_SLOT   = DESC_WORDS - 1;
  localparam int GO_POS     = 31;

  // register word indices
  localparam logic [2:0] SEL_STAT = 3'd0;
  localparam logic [2:0] SEL_CTRL = 3'd1;
  localparam logic [2:0] SEL_FILL = 3'd2;
  localparam logic [2:0] SEL_RESP = 3'd3;
  localparam logic [2:0] SEL_SEQ  = 3'd4;

  // status bit positions
  localparam int ST_BUSY  = 0;
  localparam int ST_DEMP  = 1;
  localparam int ST_DFULL = 2;
  localparam int ST_REMP  = 3;
  localparam int ST_RFULL = 4;
  localparam int ST_STOP  = 5;
  localparam int ST_RST   = 6;
  localparam int ST_ERR   = 7;
  localparam int ST_EARLY = 8;
  localparam int ST_IRQ   = 9;
  localparam int ST_OVF   = 10;

  // control bit positions
  localparam int CT_HALT  = 0;
  localparam int CT_RESET = 1;
  localparam int CT_SERR  = 2;
  localparam int CT_SEARL = 3;
  localparam int CT_GIE   = 4;
  localparam int CT_NOFET = 5;

  typedef struct packed {
    logic no_fetch;
    logic gie;
    logic stop_early;
    logic stop_err;
    logic halt;
  } ctrl_t;

  function automatic ctrl_t ctrl_from_word(input logic [WORD_W-1:0] w);
    ctrl_t c;
    c.halt       = w[CT_HALT];
    c.stop_err   = w[CT_SERR];
    c.stop_early = w[CT_SEARL];
    c.gie        = w[CT_GIE];
    c.no_fetch   = w[CT_NOFET];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] ctrl_to_word(input ctrl_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[CT_HALT]  = c.halt;
    w[CT_SERR]  = c.stop_err;
    w[CT_SEARL] = c.stop_early;
    w[CT_GIE]   = c.gie;
    w[CT_NOFET] = c.no_fetch;
    return w;
  endfunction

  // interrupt cause for one completion, from the descriptor control word
  function automatic logic irq_cause(input logic [WORD_W-1:0] dctl,
                                     input logic [7:0] err,
                                     input logic early);
    return dctl[14] | (|(err & dctl[23:16])) | (early & dctl[15]);
  endfunction
endpackage

// File: rtl/dd_fifo.sv
module dd_fifo #(
  parameter int WIDTH = 256,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [WIDTH-1:0]             din,
  input  logic                         pop,
  output logic [WIDTH-1:0]             dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         empty,
  output logic                         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign dout  = mem[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) begin
        mem[wptr] <= din;
        wptr      <= bump(wptr);
      end
      if (pop) rptr <= bump(rptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assert_no_push_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_pop_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/dd_stage.sv
module dd_stage
  import dd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr,
  input  logic [SLOT_W-1:0] slot,
  input  logic [WORD_W-1:0] wdata,
  input  logic              fifo_full,
  output logic              push,
  output logic              drop,
  output logic [DESC_W-1:0] entry
);
  logic [WORD_W-1:0] words [DESC_WORDS];
  logic go_wr;

  assign go_wr = wr && (slot == SLOT_W'(CTL_SLOT)) && wdata[GO_POS];
  assign push  = go_wr && !fifo_full && !flush;
  assign drop  = go_wr && fifo_full && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DESC_WORDS; i++) words[i] <= '0;
    end else if (flush) begin
      for (int i = 0; i < DESC_WORDS; i++) words[i] <= '0;
    end else if (wr) begin
      words[slot] <= wdata;
    end
  end

  // the committing control word bypasses its own staging register
  for (genvar k = 0; k < DESC_WORDS; k++) begin : g_pack
    if (k == CTL_SLOT) begin : g_ctl
      assign entry[k*WORD_W +: WORD_W] = wdata;
    end else begin : g_data
      assign entry[k*WORD_W +: WORD_W] = words[k];
    end
  end
endmodule

// File: rtl/dd_csr.sv
module dd_csr
  import dd_pkg::*;
#(
  parameter int RST_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic [2:0]        csr_addr,
  input  logic [WORD_W-1:0] csr_wdata,
  input  logic              done_fire,
  input  logic [7:0]        done_err,
  input  logic              done_early,
  input  logic [WORD_W-1:0] done_ctl,
  input  logic              drop,
  output ctrl_t             ctrl_q,
  output logic              resetting,
  output logic              err_f,
  output logic              early_f,
  output logic              irq_f,
  output logic              ovf_f
);
  localparam int CW = $clog2(RST_CYC+1);

  logic [CW-1:0] rst_cnt;
  logic wr_ctrl, wr_stat, raise, err_hit, early_hit;

  assign wr_ctrl   = csr_wr && (csr_addr == SEL_CTRL);
  assign wr_stat   = csr_wr && (csr_addr == SEL_STAT);
  assign resetting = (rst_cnt != '0);
  assign raise     = done_fire && irq_cause(done_ctl, done_err, done_early);
  assign err_hit   = done_fire && ctrl_q.stop_err && (|done_err);
  assign early_hit = done_fire && ctrl_q.stop_early && done_early;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      rst_cnt <= '0;
      err_f   <= 1'b0;
      early_f <= 1'b0;
      irq_f   <= 1'b0;
      ovf_f   <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_from_word(csr_wdata);
      if (wr_ctrl && csr_wdata[CT_RESET]) rst_cnt <= CW'(RST_CYC);
      else if (resetting)                  rst_cnt <= rst_cnt - 1'b1;

      if (resetting) begin
        err_f   <= 1'b0;
        early_f <= 1'b0;
        ovf_f   <= 1'b0;
      end else begin
        if (wr_stat && csr_wdata[ST_ERR])   err_f   <= 1'b0;
        if (wr_stat && csr_wdata[ST_EARLY]) early_f <= 1'b0;
        if (wr_stat && csr_wdata[ST_OVF])   ovf_f   <= 1'b0;
        if (err_hit)   err_f   <= 1'b1;
        if (early_hit) early_f <= 1'b1;
        if (drop)      ovf_f   <= 1'b1;
      end

      if (wr_stat && csr_wdata[ST_IRQ]) irq_f <= 1'b0;
      if (raise)                        irq_f <= 1'b1;
    end
  end

  assert_reset_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resetting) |=> resetting);
  assert_irq_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    raise |=> irq_f);
  assert_err_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_hit |=> err_f);
  assert_ovf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovf_f);
endmodule

// File: rtl/dma_dispatch_csr.sv
module dma_dispatch_csr
  import dd_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int RST_CYC = 4,
  parameter int SEQ_W   = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         csr_wr,
  input  logic [2:0]   csr_addr,
  input  logic [31:0]  csr_wdata,
  output logic [31:0]  csr_rdata,
  input  logic         dsc_wr,
  input  logic [2:0]   dsc_addr,
  input  logic [31:0]  dsc_wdata,
  output logic         xfer_valid,
  input  logic         xfer_ready,
  output logic [255:0] xfer_desc,
  input  logic         done_valid,
  input  logic [7:0]   done_err,
  input  logic         done_early,
  output logic         irq
);
  localparam int CNT_W  = $clog2(DEPTH+1);
  localparam int HALF_W = WORD_W / 2;

  logic              push, drop, pop, empty, full;
  logic [DESC_W-1:0] entry;
  logic [CNT_W-1:0]  count;
  ctrl_t             ctrl_q;
  logic              resetting, err_f, early_f, irq_f, ovf_f;
  logic              busy_q, done_fire, stopped;
  logic [WORD_W-1:0] held_ctl;
  logic [SEQ_W-1:0]  seq_out, seq_done;
  logic [WORD_W-1:0] status;

  dd_stage u_stage (
    .clk(clk), .rst_n(rst_n), .flush(resetting),
    .wr(dsc_wr), .slot(dsc_addr), .wdata(dsc_wdata),
    .fifo_full(full), .push(push), .drop(drop), .entry(entry)
  );

  dd_fifo #(.WIDTH(DESC_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(resetting),
    .push(push), .din(entry), .pop(pop), .dout(xfer_desc),
    .count(count), .empty(empty), .full(full)
  );

  dd_csr #(.RST_CYC(RST_CYC)) u_csr (
    .clk(clk), .rst_n(rst_n),
    .csr_wr(csr_wr), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .done_fire(done_fire), .done_err(done_err), .done_early(done_early),
    .done_ctl(held_ctl), .drop(drop),
    .ctrl_q(ctrl_q), .resetting(resetting), .err_f(err_f),
    .early_f(early_f), .irq_f(irq_f), .ovf_f(ovf_f)
  );

  assign stopped    = ctrl_q.halt | err_f | early_f;
  assign xfer_valid = !empty && !busy_q && !stopped && !ctrl_q.no_fetch && !resetting;
  assign pop        = xfer_valid && xfer_ready;
  assign done_fire  = done_valid && busy_q && !resetting;
  assign irq        = irq_f && ctrl_q.gie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      held_ctl <= '0;
      seq_out  <= '0;
      seq_done <= '0;
    end else if (resetting) begin
      busy_q   <= 1'b0;
      seq_out  <= '0;
      seq_done <= '0;
    end else begin
      if (pop) begin
        busy_q   <= 1'b1;
        held_ctl <= xfer_desc[CTL_SLOT*WORD_W +: WORD_W];
        seq_out  <= seq_out + 1'b1;
      end else if (done_fire) begin
        busy_q   <= 1'b0;
      end
      if (done_fire) seq_done <= seq_done + 1'b1;
    end
  end

  always_comb begin
    status           = '0;
    status[ST_BUSY]  = !empty || busy_q;
    status[ST_DEMP]  = empty;
    status[ST_DFULL] = full;
    status[ST_REMP]  = !busy_q;
    status[ST_RFULL] = busy_q;
    status[ST_STOP]  = stopped;
    status[ST_RST]   = resetting;
    status[ST_ERR]   = err_f;
    status[ST_EARLY] = early_f;
    status[ST_IRQ]   = irq_f;
    status[ST_OVF]   = ovf_f;
  end

  always_comb begin
    case (csr_addr)
      SEL_STAT: csr_rdata = status;
      SEL_CTRL: csr_rdata = ctrl_to_word(ctrl_q);
      SEL_FILL: csr_rdata = {HALF_W'(count), HALF_W'(count)};
      SEL_RESP: csr_rdata = WORD_W'(busy_q);
      SEL_SEQ:  csr_rdata = {HALF_W'(seq_done), HALF_W'(seq_out)};
      default:  csr_rdata = '0;
    endcase
  end

  assert_one_inflight_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !xfer_valid);
  assert_no_offer_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_f || early_f) |-> !xfer_valid);
endmodule

// File: tb/sim_dma_dispatch_csr.sv
module sim_dma_dispatch_csr;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         csr_wr = 1'b0;
  logic [2:0]   csr_addr = '0;
  logic [31:0]  csr_wdata = '0;
  logic [31:0]  csr_rdata;
  logic         dsc_wr = 1'b0;
  logic [2:0]   dsc_addr = '0;
  logic [31:0]  dsc_wdata = '0;
  logic         xfer_valid;
  logic         xfer_ready = 1'b0;
  logic [255:0] xfer_desc;
  logic         done_valid = 1'b0;
  logic [7:0]   done_err = '0;
  logic         done_early = 1'b0;
  logic         irq;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dma_dispatch_csr u0 (.*);

  // {mask[7:0], cmp_irq, early_irq, err[7:0], early, expect}
  localparam logic [19:0] TBL [8] = '{
    {8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1},
    {8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
    {8'hFF, 1'b0, 1'b0, 8'h01, 1'b0, 1'b1},
    {8'h0F, 1'b0, 1'b0, 8'hF0, 1'b0, 1'b0},
    {8'h0F, 1'b0, 1'b0, 8'h08, 1'b0, 1'b1},
    {8'h00, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1},
    {8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0},
    {8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic csr_write(input logic [2:0] a, input logic [31:0] d);
    csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_wr = 1'b0; csr_wdata = '0;
  endtask

  function automatic logic [31:0] rd(input logic [2:0] a);
    csr_addr = a;
    return csr_rdata;
  endfunction

  task automatic slot_write(input logic [2:0] s, input logic [31:0] d);
    dsc_wr = 1'b1; dsc_addr = s; dsc_wdata = d;
    @(negedge clk);
    dsc_wr = 1'b0;
  endtask

  task automatic accept();
    xfer_ready = 1'b1;
    @(negedge clk);
    xfer_ready = 1'b0;
  endtask

  task automatic complete(input logic [7:0] e, input logic early);
    done_valid = 1'b1; done_err = e; done_early = early;
    @(negedge clk);
    done_valid = 1'b0; done_err = '0; done_early = 1'b0;
  endtask

  task automatic read_stat(output logic [31:0] s);
    csr_addr = 3'd0;
    #1 s = csr_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0]  st;
    logic [255:0] exp_desc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    read_stat(st);
    check("R1 status", st, 32'h0000_000A);
    csr_addr = 3'd2; #1 check("R1 fill", csr_rdata, 0);
    csr_addr = 3'd4; #1 check("R1 seq", csr_rdata, 0);
    check("R1 valid/irq", {xfer_valid, irq}, 2'b00);

    // R6/R2: interrupt cause table with full descriptor compare
    csr_write(3'd1, 32'h10);
    for (int i = 0; i < 8; i++) begin
      logic [31:0] ctl;
      ctl = 32'h8000_0000 | (32'(TBL[i][19:12]) << 16)
          | (32'(TBL[i][11]) << 14) | (32'(TBL[i][10]) << 15);
      exp_desc = '0;
      for (int k = 0; k < 7; k++) begin
        slot_write(3'(k), 32'hA000_0000 + (i << 8) + k);
        exp_desc[k*32 +: 32] = 32'hA000_0000 + (i << 8) + k;
      end
      exp_desc[255:224] = ctl;
      slot_write(3'd7, ctl);
      check("R2 descriptor image", xfer_desc, exp_desc);
      check("R5 offered", xfer_valid, 1'b1);
      accept();
      complete(TBL[i][9:2], TBL[i][1]);
      read_stat(st);
      check("R6 irq flag", st[9], TBL[i][0]);
      check("R7 irq out", irq, TBL[i][0]);
      csr_write(3'd0, 32'h200);
      read_stat(st);
      check("R6 irq clear", st[9], 1'b0);
    end
    csr_addr = 3'd4; #1 check("R5 sequence counts", csr_rdata, 32'h0008_0008);

    // R2: go clear pushes nothing; R4/R3: fill, full, overflow
    csr_write(3'd1, 32'h30);
    slot_write(3'd7, 32'h0000_4000);
    csr_addr = 3'd2; #1 check("R2 no go no push", csr_rdata, 0);
    for (int n = 0; n < 4; n++) slot_write(3'd7, 32'h8000_0000 | n);
    read_stat(st);
    check("R4 full/busy bits", st[4:0], 5'b01101);
    csr_addr = 3'd2; #1 check("R4 fill level", csr_rdata, 32'h0004_0004);
    check("R5 stop fetching holds off", xfer_valid, 1'b0);
    slot_write(3'd7, 32'h8000_0099);
    read_stat(st);
    check("R3 overflow flag", st[10], 1'b1);
    csr_addr = 3'd2; #1 check("R3 dropped entry", csr_rdata, 32'h0004_0004);
    csr_write(3'd0, 32'h400);
    read_stat(st);
    check("R3 overflow clear", st[10], 1'b0);

    // R9: soft reset
    slot_write(3'd0, 32'hDEAD_BEEF);
    csr_write(3'd1, 32'h32);
    for (int c = 0; c < 4; c++) begin
      read_stat(st);
      check("R9 resetting high", st[6], 1'b1);
      if (c == 1) begin
        slot_write(3'd7, 32'h8000_0000);
      end else begin
        @(negedge clk);
      end
    end
    read_stat(st);
    check("R9 resetting low", st[6], 1'b0);
    check("R9 fifo flushed", st, 32'h0000_000A);
    csr_addr = 3'd1; #1 check("R10 control readback", csr_rdata, 32'h30);

    // R9 staging flushed; R8 stop on error
    csr_write(3'd1, 32'h14);
    slot_write(3'd7, 32'h8000_0000);
    check("R9 staging cleared", xfer_desc[31:0], 32'h0);
    accept();
    complete(8'h04, 1'b0);
    slot_write(3'd7, 32'h8000_4000);
    read_stat(st);
    check("R8 stop error bits", {st[7], st[5]}, 2'b11);
    check("R8 dispatch halted", xfer_valid, 1'b0);
    csr_write(3'd0, 32'h80);
    check("R8 resume", xfer_valid, 1'b1);
    accept();
    complete(8'h00, 1'b0);

    // R7: interrupt gating
    read_stat(st);
    check("R7 gie on", {st[9], irq}, 2'b11);
    csr_write(3'd1, 32'h08);
    read_stat(st);
    check("R7 gie off", {st[9], irq}, 2'b10);
    csr_write(3'd0, 32'h200);

    // R8: stop on early termination and halt bit
    slot_write(3'd7, 32'h8000_0000);
    accept();
    complete(8'h00, 1'b1);
    read_stat(st);
    check("R8 early stop bits", {st[8], st[5]}, 2'b11);
    csr_write(3'd0, 32'h100);
    csr_write(3'd1, 32'h01);
    slot_write(3'd7, 32'h8000_0000);
    read_stat(st);
    check("R8 halt bit", {st[5], xfer_valid}, 2'b10);
    csr_write(3'd1, 32'h00);
    check("R8 halt released", xfer_valid, 1'b1);
    csr_addr = 3'd1; #1 check("R10 control zero", csr_rdata, 32'h0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule